// File: doc/BRIEF.md
# Soft-Power Wake Event Latch

This block sits in the always-on domain of a soft power controller. It watches four slow, asynchronous sources: two serial receive lines, an active-low ring indicator and an active-low push button. It records a falling edge on any of them as a sticky bit in a status byte. A strobe on the read port returns that byte and clears it. The enabled receive-line and ring bits are combined into a wake request that drives the power-on logic. The button bit is recorded for software only and never wakes the system.

The block also holds a power-off delay timer. A 6-bit delay code sits in a small write-only register that clears to zero on reset. When the power-off enable and the delayed-off option are both set, a button press arms the timer. The timer then counts `(code+1)` steps, and each step is `STEP_TICKS` pulses of a 1 kHz enable (500 by default, so one step is 500 ms). When the count is done, the block raises a one-cycle power-off pulse. All sources pass through a two-stage synchroniser before edge detection.

Top module: `softpwr_wake_latch`

## Requirements
- R1: A falling edge on `rxa_i` sets `stat_o[0]`, and one on `rxb_i` sets `stat_o[1]`. The bit is visible after the third rising clock edge that follows the input change.
- R2: A falling edge on `ring_n_i` sets `stat_o[3]` with the same latency as R1.
- R3: A falling edge on `btn_n_i` sets `stat_o[2]`. That bit never contributes to `wake_req_o`.
- R4: On an edge where `stat_rd_i` is high, every status bit clears, except a bit whose source edge is detected on that same clock edge, which stays set. `stat_o[7:4]` are always zero.
- R5: `wake_req_o` is the OR of `stat_o[0]&wake_en_rxa_i`, `stat_o[1]&wake_en_rxb_i` and `stat_o[3]&wake_en_ring_i`. It is registered together with the status byte, using the enables sampled on that clock edge.
- R6: The delay code register resets to 0. It loads `dly_wdata_i` on an edge with `dly_wr_i` high. After reset, with no write, the delay is one step.
- R7: The timer arms only when a button edge is detected on the same clock edge where `off_en_i` and `off_dly_en_i` are both high. The delay is `(code+1)*STEP_TICKS` sampled `ms_tick_i` pulses, and a tick on the arming edge is not counted.
- R8: On expiry, `off_pulse_o` is high for exactly one cycle and the timer returns to idle. A button press while the timer is counting neither restarts nor extends it.
- R9: After reset, `stat_o`, `wake_req_o` and `off_pulse_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxa_i | input | 1 | First serial receive line (async) |
| rxb_i | input | 1 | Second serial receive line (async) |
| ring_n_i | input | 1 | Ring indicator, active low (async) |
| btn_n_i | input | 1 | Power button, active low (async) |
| off_en_i | input | 1 | Power-off function enable |
| off_dly_en_i | input | 1 | Delayed power-off option |
| dly_wr_i | input | 1 | Write strobe for the delay code |
| dly_wdata_i | input | 6 | Delay code write data |
| ms_tick_i | input | 1 | 1 kHz count enable |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| wake_en_rxa_i | input | 1 | Wake enable for the first receive line |
| wake_en_rxb_i | input | 1 | Wake enable for the second receive line |
| wake_en_ring_i | input | 1 | Wake enable for the ring indicator |
| stat_o | output | 8 | Latched status byte |
| wake_req_o | output | 1 | Power-on wake request |
| off_pulse_o | output | 1 | One-cycle power-off request |

## Verification
A source change shows up in `stat_o` and `wake_req_o` after three rising edges: two synchroniser stages, then the status register. A read or an enable change takes effect after one edge. The power-off pulse appears `(code+1)*STEP_TICKS` counted ticks after the arming edge, and the arming edge is itself three edges after the button falls. The bench model keeps a three-deep history of each sampled input and applies every result on the same edge as the design. Outputs are compared at the falling clock edge, and directed timing checks count rising edges from the input change to the pulse.

// File: rtl/softpwr_pkg.sv
package softpwr_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SRC_RXA   = 0;
  localparam int SRC_RXB   = 1;
  localparam int SRC_BTN   = 2;
  localparam int SRC_RING  = 3;
  localparam int STAT_W    = 8;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/sp_status_reg.sv
module sp_status_reg
  import softpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  src_vec_t          fall_i,
  input  logic              rd_i,
  input  src_vec_t          wake_en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              wake_o
);
  src_vec_t st_q, st_nxt;
  logic     wake_q;

  always_comb begin
    st_nxt = (rd_i ? '0 : st_q) | fall_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      wake_q <= |(st_nxt & wake_en_i);
    end
  end

  assign stat_o = {{(STAT_W-NUM_SRC){1'b0}}, st_q};
  assign wake_o = wake_q;

  // R1
  set_rxa_chk: assert property (@(posedge clk) disable iff (rst)
    fall_i[SRC_RXA] |=> stat_o[SRC_RXA]);
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> ((stat_o[NUM_SRC-1:0] & ~$past(fall_i)) == '0));
  // R5
  wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ((stat_o[SRC_RXA] | stat_o[SRC_RXB] | stat_o[SRC_RING]) == 1'b1));
endmodule

// File: rtl/sp_off_timer.sv
module sp_off_timer #(
  parameter int CODE_W     = 6,
  parameter int STEP_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              press_i,
  input  logic              off_en_i,
  input  logic              dly_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              pulse_o
);
  localparam int SUB_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam int PER_W = CODE_W + 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(STEP_TICKS - 1);

  logic             busy_q;
  logic [SUB_W-1:0] sub_q;
  logic [PER_W-1:0] per_q;
  logic             pulse_q;
  logic             arm;

  assign arm = press_i & off_en_i & dly_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      sub_q   <= '0;
      per_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (!busy_q) begin
        if (arm) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          per_q  <= {1'b0, code_i} + PER_W'(1);
        end
      end else if (tick_i) begin
        if (sub_q == SUB_LAST) begin
          sub_q <= '0;
          if (per_q == PER_W'(1)) begin
            busy_q  <= 1'b0;
            pulse_q <= 1'b1;
          end else begin
            per_q <= per_q - PER_W'(1);
          end
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R8
  pulse_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(busy_q));
  // R7
  arm_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !(press_i && off_en_i && dly_en_i)) |=> !busy_q);
endmodule

// File: rtl/softpwr_wake_latch.sv
module softpwr_wake_latch
  import softpwr_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int STEP_TICKS  = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxa_i,
  input  logic              rxb_i,
  input  logic              ring_n_i,
  input  logic              btn_n_i,
  input  logic              off_en_i,
  input  logic              off_dly_en_i,
  input  logic              dly_wr_i,
  input  logic [CODE_W-1:0] dly_wdata_i,
  input  logic              ms_tick_i,
  input  logic              stat_rd_i,
  input  logic              wake_en_rxa_i,
  input  logic              wake_en_rxb_i,
  input  logic              wake_en_ring_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              wake_req_o,
  output logic              off_pulse_o
);
  src_vec_t raw, fall, wen;
  logic [CODE_W-1:0] code_q;

  // every source is idle high and active on its falling edge
  assign raw = {ring_n_i, btn_n_i, rxb_i, rxa_i};
  // the button never feeds the wake path
  assign wen = {wake_en_ring_i, 1'b0, wake_en_rxb_i, wake_en_rxa_i};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    sp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d_i    (raw[i]),
      .fall_o (fall[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           code_q <= '0;
    else if (dly_wr_i) code_q <= dly_wdata_i;
  end

  sp_status_reg u_stat (
    .clk       (clk),
    .rst       (rst),
    .fall_i    (fall),
    .rd_i      (stat_rd_i),
    .wake_en_i (wen),
    .stat_o    (stat_o),
    .wake_o    (wake_req_o)
  );

  sp_off_timer #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .press_i  (fall[SRC_BTN]),
    .off_en_i (off_en_i),
    .dly_en_i (off_dly_en_i),
    .code_i   (code_q),
    .tick_i   (ms_tick_i),
    .pulse_o  (off_pulse_o)
  );

  // R6
  code_load_chk: assert property (@(posedge clk) disable iff (rst)
    dly_wr_i |=> (code_q == $past(dly_wdata_i)));
endmodule

// File: tb/softpwr_wake_latch_test.sv
module softpwr_wake_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_a = 1, rx_b = 1, ring_n = 1, btn_n = 1;
  logic off_en = 0, dly_en = 0, code_wr = 0, tick = 0, rd_en = 0;
  logic [5:0] code_wd = '0;
  logic wen_a = 0, wen_b = 0, wen_ring = 0;
  logic [7:0] stat;
  logic wake, offp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softpwr_wake_latch #(.STEP_TICKS(STEP)) uut (
    .clk(clk), .rst(rst), .rxa_i(rx_a), .rxb_i(rx_b), .ring_n_i(ring_n),
    .btn_n_i(btn_n), .off_en_i(off_en), .off_dly_en_i(dly_en),
    .dly_wr_i(code_wr), .dly_wdata_i(code_wd), .ms_tick_i(tick),
    .stat_rd_i(rd_en), .wake_en_rxa_i(wen_a), .wake_en_rxb_i(wen_b),
    .wake_en_ring_i(wen_ring), .stat_o(stat), .wake_req_o(wake),
    .off_pulse_o(offp)
  );

  // ---------------- behavioural reference model ----------------
  int h1[4], h2[4], h3[4];   // input sampled 1, 2, 3 edges ago
  int m_stat[4];
  int m_wake, m_pulse, m_code, m_left;
  bit m_busy;

  always @(posedge clk) begin
    int cur[4];
    int fl[4];
    cur[0] = rx_a; cur[1] = rx_b; cur[2] = btn_n; cur[3] = ring_n;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        h1[i] = 1; h2[i] = 1; h3[i] = 1; m_stat[i] = 0;
      end
      m_wake = 0; m_pulse = 0; m_code = 0; m_left = 0; m_busy = 0;
    end else begin
      for (int i = 0; i < 4; i++) fl[i] = (h3[i] == 1 && h2[i] == 0) ? 1 : 0;
      for (int i = 0; i < 4; i++) begin
        if (rd_en) m_stat[i] = 0;
        if (fl[i] == 1) m_stat[i] = 1;
      end
      m_wake = ((m_stat[0] == 1 && wen_a) || (m_stat[1] == 1 && wen_b) ||
                (m_stat[3] == 1 && wen_ring)) ? 1 : 0;
      m_pulse = 0;
      if (!m_busy) begin
        if (fl[2] == 1 && off_en && dly_en) begin
          m_busy = 1;
          m_left = (m_code + 1) * STEP;
        end
      end else if (tick) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_pulse = 1;
        end
      end
      if (code_wr) m_code = code_wd;
      for (int i = 0; i < 4; i++) begin
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = cur[i];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(stat[0] == m_stat[0][0], "R1 rxa bit", int'(stat[0]), m_stat[0]);
      check(stat[1] == m_stat[1][0], "R1 rxb bit", int'(stat[1]), m_stat[1]);
      check(stat[2] == m_stat[2][0], "R3 button bit", int'(stat[2]), m_stat[2]);
      check(stat[3] == m_stat[3][0], "R2 ring bit", int'(stat[3]), m_stat[3]);
      check(stat[7:4] == 4'h0, "R4 upper bits", int'(stat[7:4]), 0);
      check(wake == m_wake[0], "R5 wake", int'(wake), m_wake);
      check(offp == m_pulse[0], "R7 off pulse", int'(offp), m_pulse);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press button, count rising edges until the pulse is seen;
  // optional second press in the middle of the count
  task automatic timed_press(input bit repress, output int n);
    @(negedge clk);
    btn_n = 0;
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 3)  btn_n = 1;
      if (repress && n == 10) btn_n = 0;
      if (repress && n == 12) btn_n = 1;
      if (offp) break;
    end
    @(negedge clk);
    check(offp == 1'b0, "R8 pulse width", int'(offp), 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    model_on = 1;
    @(negedge clk);
    // R9 reset state
    check(stat == 8'h00, "R9 status after reset", int'(stat), 0);
    check(wake == 1'b0, "R9 wake after reset", int'(wake), 0);
    check(offp == 1'b0, "R9 pulse after reset", int'(offp), 0);

    // R1 latency: change before edge 1, visible after edge 3
    rx_a = 0;
    idle(2);
    check(stat[0] == 1'b0, "R1 not before third edge", int'(stat[0]), 0);
    idle(1);
    check(stat[0] == 1'b1, "R1 set after third edge", int'(stat[0]), 1);
    rx_a = 1;
    rx_b = 0; idle(4); rx_b = 1;
    check(stat[1] == 1'b1, "R1 rxb set", int'(stat[1]), 1);

    // R4 read clears
    rd_en = 1; idle(1); rd_en = 0;
    check(stat == 8'h00, "R4 cleared by read", int'(stat), 0);

    // R2 + R5 ring wake
    wen_ring = 1;
    ring_n = 0; idle(4); ring_n = 1;
    check(stat[3] == 1'b1, "R2 ring set", int'(stat[3]), 1);
    check(wake == 1'b1, "R5 ring wake", int'(wake), 1);

    // R4 edge coinciding with read survives
    rx_a = 0; idle(2); rd_en = 1; idle(1); rd_en = 0; rx_a = 1;
    check(stat == 8'h01, "R4 edge during read kept", int'(stat), 1);
    rd_en = 1; idle(1); rd_en = 0;

    // R3 button does not wake
    wen_a = 1; wen_b = 1;
    btn_n = 0; idle(4); btn_n = 1;
    check(stat[2] == 1'b1, "R3 button latched", int'(stat[2]), 1);
    check(wake == 1'b0, "R3 button no wake", int'(wake), 0);
    rd_en = 1; idle(1); rd_en = 0;

    // R7 no arm when delayed option off
    tick = 1; off_en = 1; dly_en = 0;
    btn_n = 0; idle(3); btn_n = 1;
    idle(3 * STEP + 10);
    check(offp == 1'b0, "R7 no arm without option", int'(offp), 0);

    // R6 default code 0 -> one step
    dly_en = 1;
    timed_press(0, n);
    check(n == 3 + STEP, "R6 default delay", n, 3 + STEP);

    // R7 code 63
    code_wd = 6'd63; code_wr = 1; idle(1); code_wr = 0;
    timed_press(0, n);
    check(n == 3 + 64 * STEP, "R7 max delay", n, 3 + 64 * STEP);

    // R8 second press ignored
    code_wd = 6'd5; code_wr = 1; idle(1); code_wr = 0;
    timed_press(1, n);
    check(n == 3 + 6 * STEP, "R8 repress ignored", n, 3 + 6 * STEP);

    // mixed random traffic, checked against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) rx_a = ~rx_a;
      if ($urandom_range(0, 7) == 0) rx_b = ~rx_b;
      if ($urandom_range(0, 9) == 0) ring_n = ~ring_n;
      if ($urandom_range(0, 15) == 0) btn_n = ~btn_n;
      rd_en   = ($urandom_range(0, 5) == 0);
      tick    = ($urandom_range(0, 1) == 0);
      code_wr = ($urandom_range(0, 63) == 0);
      code_wd = 6'($urandom_range(0, 7));
      if ($urandom_range(0, 31) == 0) begin
        off_en = $urandom_range(0, 1) == 1;
        dly_en = $urandom_range(0, 1) == 1;
        wen_a = $urandom_range(0, 1) == 1;
        wen_b = $urandom_range(0, 1) == 1;
        wen_ring = $urandom_range(0, 1) == 1;
      end
    end
    code_wr = 0; rd_en = 0;
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule